// File: doc/BRIEF.md
# Symmetric FIR Configuration and Pre-Adder

This block keeps the 16-bit control word of a symmetric decimating FIR filter and turns it into the parameters that the rest of the datapath runs with. A processor-style port writes the word. The port has write and select strobes, a two-bit register address and a 16-bit data bus. Only address 0 belongs to this block. A write to any other address goes to registers that live elsewhere, and this block ignores it.

From the stored word the block produces six outputs: the effective tap count, the effective decimation factor, the add/subtract choice for the pre-adder, the choice that zeroes one pre-adder input, a bypass flag, and a flag that says the coefficients must be reloaded. The block also contains the pre-adder. It takes the two mirrored samples of the delay line and gives one widened sum or difference to the multiplier.

The bypass bit replaces every programmed field with a fixed setup: 3 taps, even symmetry, no decimation, and one side of the pre-adder zeroed. When bypass is cleared, a sticky flag asks for a coefficient reload. When bypass is set, the downstream output path is expected to use only the low 16 bits of its bus.

Top module: `symfir_cfg_top`

## Requirements
- R1: Reset clears the control word to zero. The outputs then show 3 taps with the clamp flag set, decimation 1, subtract mode, no zeroing, bypass off and no reload request.
- R2: The word is loaded from `bus_data` on a clock edge when `bus_wr` and `bus_sel` are both 1 and `bus_addr` is 0. The new value shows at the outputs after that edge.
- R3: Word bits 8..0 hold the tap count minus one. With bypass off and a field value of 2 or more, `eff_taps` equals the field plus one.
- R4: With bypass off, a tap field of 0 or 1 is treated as 2, so `eff_taps` is 3 and `taps_clamped` is 1. In every other case `taps_clamped` is 0.
- R5: Word bits 12..9 hold the decimation minus one. With bypass off, `eff_decim` equals the field plus one, which covers 1 to 16.
- R6: Word bit 13 picks the symmetry. A 1 makes `pre_add` 1 and `pre_sum` = a + b. A 0 makes `pre_add` 0 and `pre_sum` = a - b. Both are signed and one bit wider than a sample.
- R7: When word bit 15 is 1, `zero_side` is 1 and the b operand is taken as zero, so `pre_sum` equals a.
- R8: When word bit 14 is 1, `bypass` is 1, `eff_taps` is 3, `eff_decim` is 1, `pre_add` is 1 and `zero_side` is 1, whatever the other fields hold.
- R9: A write that clears bit 14 while it is set makes `reload_req` 1 from the next edge on. The flag stays set across later writes and clears on the first `coef_wr` pulse. If both happen on the same edge, the set wins.
- R10: A write with `bus_sel` at 0, or with `bus_addr` not 0, leaves the word and every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_sel | input | 1 | Select strobe |
| bus_addr | input | 2 | Register address, 0 selects this word |
| bus_data | input | 16 | Write data |
| coef_wr | input | 1 | Pulse for each coefficient write |
| samp_a | input | SW | Signed first pre-adder operand |
| samp_b | input | SW | Signed mirrored pre-adder operand |
| eff_taps | output | 10 | Effective tap count |
| eff_decim | output | 5 | Effective decimation factor |
| pre_add | output | 1 | 1 = add, 0 = subtract |
| zero_side | output | 1 | 1 = b operand forced to zero |
| bypass | output | 1 | Bypass mode active |
| reload_req | output | 1 | Coefficient reload pending |
| taps_clamped | output | 1 | Programmed tap field was below 2 |
| pre_sum | output | SW+1 | Signed pre-adder result |

## Verification
The bench writes every value of the tap field and every value of the decimation field. This exposes an off-by-one that would give the wrong count, and a clamp that triggers at the wrong place, for example one that lets 2 taps through or clamps 3. It runs extreme signed operands through every symmetry and zeroing mode. A pre-adder that is too narrow would wrap there, and one that zeroes the wrong side would return b instead of a. The bench sets bypass on top of hostile field values to catch a programmed field leaking through. It also walks the reload flag through its set, hold, clear and same-edge cases, and sends writes to other addresses or without select to catch a decoder that is too loose.

// File: rtl/symfir_cfg_pkg.sv
package symfir_cfg_pkg;
  localparam int TAPW  = 9;
  localparam int DECW  = 4;
  localparam int WORDW = 3 + DECW + TAPW;
  localparam int TAP_MIN_FIELD = 2;
  localparam int BYP_TAPS = 3;

  typedef struct packed {
    logic            zero_pre;
    logic            byp;
    logic            esym;
    logic [DECW-1:0] drate;
    logic [TAPW-1:0] taps;
  } fir_word_t;

  typedef struct packed {
    logic [TAPW:0]   taps;
    logic [DECW:0]   decim;
    logic            add;
    logic            zero;
    logic            byp;
    logic            clamped;
  } fir_eff_t;

  function automatic logic [TAPW:0] taps_of(input logic [TAPW-1:0] f, input logic byp);
    if (byp) return (TAPW+1)'(BYP_TAPS);
    if (f < TAPW'(TAP_MIN_FIELD)) return (TAPW+1)'(TAP_MIN_FIELD + 1);
    return {1'b0, f} + 1'b1;
  endfunction

  function automatic logic [DECW:0] decim_of(input logic [DECW-1:0] f, input logic byp);
    if (byp) return (DECW+1)'(1);
    return {1'b0, f} + 1'b1;
  endfunction
endpackage

// File: rtl/symfir_word_reg.sv
module symfir_word_reg
  import symfir_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_sel,
  input  logic [1:0]       bus_addr,
  input  logic [WORDW-1:0] bus_data,
  input  logic             coef_wr,
  output fir_word_t        word_q,
  output logic             reload_q
);
  logic      wr_en;
  logic      leave_byp;
  fir_word_t din;

  assign din       = fir_word_t'(bus_data);
  assign wr_en     = bus_wr && bus_sel && (bus_addr == 2'd0);
  assign leave_byp = wr_en && word_q.byp && !din.byp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q   <= '0;
      reload_q <= 1'b0;
    end else begin
      if (wr_en) word_q <= din;
      if (leave_byp)    reload_q <= 1'b1;
      else if (coef_wr) reload_q <= 1'b0;
    end
  end

  a_r10_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_sel && bus_addr == 2'd0) |=> $stable(word_q));
  a_r9_reload_sets: assert property (@(posedge clk) disable iff (!rst_n)
    leave_byp |=> reload_q);
  a_r9_reload_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_wr && !leave_byp) |=> !reload_q);
  a_r9_reload_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q && !coef_wr) |=> reload_q);
endmodule

// File: rtl/symfir_cfg_decode.sv
module symfir_cfg_decode
  import symfir_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  fir_word_t word,
  output fir_eff_t  eff
);
  always_comb begin
    eff.byp     = word.byp;
    eff.taps    = taps_of(word.taps, word.byp);
    eff.decim   = decim_of(word.drate, word.byp);
    eff.add     = word.byp | word.esym;
    eff.zero    = word.byp | word.zero_pre;
    eff.clamped = !word.byp && (word.taps < TAPW'(TAP_MIN_FIELD));
  end

  a_r4_tap_floor: assert property (@(posedge clk) disable iff (!rst_n)
    eff.taps >= (TAPW+1)'(TAP_MIN_FIELD + 1));
  a_r8_bypass_forced: assert property (@(posedge clk) disable iff (!rst_n)
    word.byp |-> (eff.taps == (TAPW+1)'(BYP_TAPS) && eff.decim == (DECW+1)'(1)
                  && eff.add && eff.zero && !eff.clamped));
  a_r4_clamp_flag: assert property (@(posedge clk) disable iff (!rst_n)
    eff.clamped |-> eff.taps == (TAPW+1)'(TAP_MIN_FIELD + 1));
endmodule

// File: rtl/symfir_preadder.sv
module symfir_preadder #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_sel,
  input  logic          zero_b,
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  output logic [SW:0]   sum
);
  logic signed [SW:0] a_x, b_x;

  assign a_x = {a[SW-1], a};
  assign b_x = zero_b ? '0 : {b[SW-1], b};
  assign sum = add_sel ? (a_x + b_x) : (a_x - b_x);

  a_r7_zero_passes_a: assert property (@(posedge clk) disable iff (!rst_n)
    zero_b |-> sum == {a[SW-1], a});
endmodule

// File: rtl/symfir_cfg_top.sv
module symfir_cfg_top
  import symfir_cfg_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_sel,
  input  logic [1:0]             bus_addr,
  input  logic [WORDW-1:0]       bus_data,
  input  logic                   coef_wr,
  input  logic [SW-1:0]          samp_a,
  input  logic [SW-1:0]          samp_b,
  output logic [TAPW:0]          eff_taps,
  output logic [DECW:0]          eff_decim,
  output logic                   pre_add,
  output logic                   zero_side,
  output logic                   bypass,
  output logic                   reload_req,
  output logic                   taps_clamped,
  output logic [SW:0]            pre_sum
);
  fir_word_t word_q;
  fir_eff_t  eff;

  symfir_word_reg u_reg (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_addr(bus_addr), .bus_data(bus_data), .coef_wr(coef_wr),
    .word_q(word_q), .reload_q(reload_req)
  );

  symfir_cfg_decode u_dec (
    .clk(clk), .rst_n(rst_n), .word(word_q), .eff(eff)
  );

  symfir_preadder #(.SW(SW)) u_pre (
    .clk(clk), .rst_n(rst_n), .add_sel(eff.add), .zero_b(eff.zero),
    .a(samp_a), .b(samp_b), .sum(pre_sum)
  );

  assign eff_taps     = eff.taps;
  assign eff_decim    = eff.decim;
  assign pre_add      = eff.add;
  assign zero_side    = eff.zero;
  assign bypass       = eff.byp;
  assign taps_clamped = eff.clamped;

  a_r1_reset_state: assert property (@(posedge clk)
    $past(!rst_n) |-> (eff_taps == 10'd3 && eff_decim == 5'd1 && !pre_add
                       && !zero_side && !bypass && !reload_req));
endmodule

// File: tb/sim_symfir_cfg_top.sv
module sim_symfir_cfg_top;
  localparam int SW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_sel = 0, coef_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [15:0] bus_data = 0;
  logic [SW-1:0] samp_a = 0, samp_b = 0;
  logic [9:0] eff_taps;
  logic [4:0] eff_decim;
  logic pre_add, zero_side, bypass, reload_req, taps_clamped;
  logic [SW:0] pre_sum;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  symfir_cfg_top #(.SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_addr(bus_addr), .bus_data(bus_data), .coef_wr(coef_wr),
    .samp_a(samp_a), .samp_b(samp_b), .eff_taps(eff_taps),
    .eff_decim(eff_decim), .pre_add(pre_add), .zero_side(zero_side),
    .bypass(bypass), .reload_req(reload_req), .taps_clamped(taps_clamped),
    .pre_sum(pre_sum));

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] adr, input logic sel, input logic [15:0] d, input logic cw);
    @(negedge clk);
    bus_wr = 1; bus_sel = sel; bus_addr = adr; bus_data = d; coef_wr = cw;
    @(negedge clk);
    bus_wr = 0; bus_sel = 0; bus_addr = 0; bus_data = 16'hFFFF; coef_wr = 0;
  endtask

  task automatic coef_pulse();
    @(negedge clk); coef_wr = 1;
    @(negedge clk); coef_wr = 0;
  endtask

  function automatic longint exp_sum(input logic [SW-1:0] a, input logic [SW-1:0] b,
                                     input bit add, input bit zero);
    longint sa = longint'($signed(a));
    longint sb = zero ? 0 : longint'($signed(b));
    return add ? sa + sb : sa - sb;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 taps", eff_taps, 3);  chk("R1 clamp", taps_clamped, 1);
    chk("R1 decim", eff_decim, 1); chk("R1 add", pre_add, 0);
    chk("R1 zero", zero_side, 0); chk("R1 byp", bypass, 0);
    chk("R1 reload", reload_req, 0);

    // R2 R3 R4: sweep of the tap field
    for (int t = 0; t < 512; t++) begin
      bus_write(2'd0, 1, 16'(t), 0);
      chk("R3 taps", eff_taps, (t < 2) ? 3 : t + 1);
      chk("R4 clamp", taps_clamped, (t < 2) ? 1 : 0);
    end
    // R5: sweep of the decimation field
    for (int d = 0; d < 16; d++) begin
      bus_write(2'd0, 1, 16'((d << 9) | 100), 0);
      chk("R5 decim", eff_decim, d + 1);
      chk("R2 taps follow", eff_taps, 101);
    end

    // R6 R7: every symmetry and zeroing mode against extreme operands
    for (int m = 0; m < 4; m++) begin
      bit es = m[0], zp = m[1];
      bus_write(2'd0, 1, 16'((int'(zp) << 15) | (int'(es) << 13) | 10), 0);
      chk("R6 add flag", pre_add, es);
      chk("R7 zero flag", zero_side, zp);
      for (int i = 0; i < 6; i++) begin
        for (int j = 0; j < 6; j++) begin
          logic [SW-1:0] v [6] = '{16'h7FFF, 16'h8000, 16'h0000, 16'hFFFF, 16'h0001, 16'h1234};
          samp_a = v[i]; samp_b = v[j];
          #1;
          chk(zp ? "R7 sum" : "R6 sum", longint'($signed(pre_sum)), exp_sum(v[i], v[j], es, zp));
        end
      end
    end

    // R8: bypass overrides hostile fields
    bus_write(2'd0, 1, 16'h4000 | 16'h1E01, 0);
    chk("R8 byp", bypass, 1);   chk("R8 taps", eff_taps, 3);
    chk("R8 decim", eff_decim, 1); chk("R8 add", pre_add, 1);
    chk("R8 zero", zero_side, 1); chk("R8 clamp", taps_clamped, 0);
    samp_a = 16'h8000; samp_b = 16'h7FFF; #1;
    chk("R8 sum", longint'($signed(pre_sum)), -32768);
    chk("R9 no reload yet", reload_req, 0);

    // R10: ignored writes
    bus_write(2'd1, 1, 16'h0005, 0);
    chk("R10 addr1", bypass, 1);
    bus_write(2'd3, 1, 16'h0005, 0);
    chk("R10 addr3", eff_taps, 3);
    bus_write(2'd0, 0, 16'h0005, 0);
    chk("R10 nosel", bypass, 1);
    chk("R10 reload", reload_req, 0);

    // R9: leave bypass, sticky, clear, set wins
    bus_write(2'd0, 1, 16'h2010, 0);
    chk("R9 set", reload_req, 1);
    chk("R9 taps after", eff_taps, 17);
    bus_write(2'd0, 1, 16'h2020, 0);
    chk("R9 sticky", reload_req, 1);
    coef_pulse();
    chk("R9 clear", reload_req, 0);
    coef_pulse();
    chk("R9 stays clear", reload_req, 0);
    bus_write(2'd0, 1, 16'h4000, 0);
    bus_write(2'd0, 1, 16'h0000, 1);
    chk("R9 set wins", reload_req, 1);

    // R1 again: reset in mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R1 rereset reload", reload_req, 0);
    chk("R1 rereset taps", eff_taps, 3);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule